// File: doc/BRIEF.md
# HDLC Frame Receiver

This block takes a serial HDLC line, one bit sampled on each rising clock edge, and turns it into a byte stream framed by start and end markers. It locates the 01111110 delimiter at any bit position, drops the zero that a transmitter inserts after five consecutive ones, and assembles the remaining bits into bytes, least significant bit first. Every frame that holds at least one whole byte finishes with a single status pulse that marks it good or bad. A downstream packet buffer writes the data bytes as they arrive and flushes the frame when the status says bad.

The last two whole bytes of a frame are its check sequence. They go through a two-byte delay line, so when the closing delimiter arrives the receiver can drop them instead of passing them on. A frame is good only if its bit count is a multiple of eight, its length including the check bytes lies within the configured limits, and its CRC residue is correct. Seven ones in a row abort the current frame. Fifteen ones in a row flag the line as idle.

Top module: `hdlc_rx_deframer`

## Requirements
- R1: The pattern 01111110 is recognised as a delimiter at any bit position. Runs of delimiters, back to back or sharing a single zero (011111101111110), produce neither data nor status.
- R2: Inside a frame, a 0 that directly follows five consecutive 1s is removed before byte assembly.
- R3: Bytes are assembled least significant bit first. The first bit received after destuffing becomes bit 0 of `out_data`.
- R4: A frame that held at least one whole byte ends with exactly one `fr_done` pulse, never in the same cycle as `out_valid`. `fr_ok` is high only together with `fr_done`.
- R5: The check is CRC-16 with polynomial x^16+x^12+x^5+1, preset 0xFFFF, bits taken LSB first. The transmitter sends the one's complement of the CRC, low byte first. A frame whose bytes, including that check field, do not leave the residue 0xF0B8 is bad.
- R6: A frame whose byte count including the 2 check bytes is below MIN_LEN (62) or above MAX_LEN (1534) is bad. Lengths of exactly 62 and exactly 1534 are good.
- R7: Data bytes are every whole byte assembled since the opening delimiter except the final two, in order, whatever the final status. `out_first` marks the first of them.
- R8: A frame whose destuffed bit count before the closing delimiter is not a multiple of 8 is bad.
- R9: Seven consecutive 1s inside a frame end it as bad. Bits are then ignored until the next delimiter.
- R10: `line_idle` is high in every cycle after fifteen or more consecutive 1s have been sampled, and goes low after a 0 is sampled.
- R11: After reset all outputs are low, and the receiver ignores every bit until it has seen a delimiter.
- R12: A single delimiter both closes one frame and opens the next. Both frames are delivered in full.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Receive bit clock; data sampled on the rising edge |
| rst | input | 1 | Synchronous active-high reset |
| rx_bit | input | 1 | Serial line data |
| out_valid | output | 1 | One-cycle strobe: `out_data` holds a payload byte |
| out_data | output | 8 | Payload byte |
| out_first | output | 1 | High with `out_valid` on the first byte of a frame |
| fr_done | output | 1 | One-cycle strobe: the current frame has ended |
| fr_ok | output | 1 | With `fr_done`: frame is good (low means flush it) |
| line_idle | output | 1 | Fifteen or more consecutive ones seen on the line |

## Verification
Two events can land on the same bit. The first is a delimiter that closes one frame and opens the next: the status for the first frame and the start of the next frame's byte assembly happen on the same sampled bit. The bench drives back-to-back frames separated by one delimiter, and by two delimiters sharing a zero, and compares both frames' byte streams and statuses against an expected-event queue. The second is an abort that follows a run of ones straight after a byte boundary, so that status and idle tracking overlap. The bench checks the bad status, the withheld bytes and the idle flag, which is compared against a behavioural run counter on every clock.

// File: rtl/hdlc_rx_pkg.sv
package hdlc_rx_pkg;

  localparam logic [15:0] CRC_PRESET   = 16'hFFFF;
  localparam logic [15:0] CRC_RESIDUE  = 16'hF0B8;
  localparam logic [15:0] CRC_POLY_REV = 16'h8408;

  typedef enum logic {ST_HUNT, ST_FRAME} rx_state_t;

  // One byte through the reflected CRC-16 (R5), LSB first.
  function automatic logic [15:0] crc16_byte(input logic [15:0] c, input logic [7:0] d);
    logic [15:0] r;
    r = c;
    for (int i = 0; i < 8; i++) begin
      if (r[0] ^ d[i]) r = (r >> 1) ^ CRC_POLY_REV;
      else             r = r >> 1;
    end
    return r;
  endfunction

endpackage

// File: rtl/hdlc_rx_flagdet.sv
// Run-of-ones tracker: delimiter, abort, stuffed-zero and idle decode.
module hdlc_rx_flagdet #(
  parameter int ABORT_RUN = 7,
  parameter int IDLE_RUN  = 15
) (
  input  logic clk,
  input  logic rst,
  input  logic rx_bit,
  input  logic in_frame,
  output logic bit_take,
  output logic ev_flag,
  output logic ev_abort,
  output logic line_idle
);
  localparam int RUN_W = $clog2(IDLE_RUN + 1);
  localparam logic [RUN_W-1:0] FLAG_RUN  = RUN_W'(ABORT_RUN - 1);
  localparam logic [RUN_W-1:0] STUFF_RUN = RUN_W'(ABORT_RUN - 2);
  localparam logic [RUN_W-1:0] IDLE_V    = RUN_W'(IDLE_RUN);

  logic [RUN_W-1:0] run_q;

  always_comb begin
    bit_take = 1'b0;
    ev_flag  = 1'b0;
    ev_abort = 1'b0;
    if (rx_bit) begin
      if (run_q == FLAG_RUN)     ev_abort = 1'b1;      // R9
      else if (run_q < FLAG_RUN) bit_take = in_frame;
    end else begin
      if (run_q == FLAG_RUN)      ev_flag  = 1'b1;     // R1
      else if (run_q < STUFF_RUN) bit_take = in_frame; // R2: run of 5 drops the 0
    end
  end

  always_ff @(posedge clk) begin
    if (rst)                  run_q <= '0;
    else if (!rx_bit)         run_q <= '0;
    else if (run_q != IDLE_V) run_q <= run_q + 1'b1;
  end

  assign line_idle = (run_q == IDLE_V); // R10

endmodule

// File: rtl/hdlc_rx_packer.sv
// Serial-to-byte assembly, LSB first (R3), with whole-byte counter.
module hdlc_rx_packer #(
  parameter int MAX_LEN = 1534
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clear,
  input  logic             bit_take,
  input  logic             bit_val,
  output logic             byte_stb,
  output logic [7:0]       byte_val,
  output logic [2:0]       phase,
  output logic [$clog2(MAX_LEN+2)-1:0] nbytes
);
  localparam int CNT_W = $clog2(MAX_LEN + 2);
  localparam logic [CNT_W-1:0] CNT_SAT = CNT_W'(MAX_LEN + 1);

  logic [6:0] shreg_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      shreg_q  <= '0;
      phase    <= '0;
      nbytes   <= '0;
      byte_stb <= 1'b0;
      byte_val <= '0;
    end else begin
      byte_stb <= 1'b0;
      if (clear) begin
        phase  <= '0;
        nbytes <= '0;
      end else if (bit_take) begin
        shreg_q <= {bit_val, shreg_q[6:1]};
        phase   <= phase + 1'b1;
        if (phase == 3'd7) begin
          byte_stb <= 1'b1;
          byte_val <= {bit_val, shreg_q};
          if (nbytes != CNT_SAT) nbytes <= nbytes + 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/hdlc_rx_crc16.sv
module hdlc_rx_crc16
  import hdlc_rx_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        init,
  input  logic        stb,
  input  logic [7:0]  data,
  output logic [15:0] crc_q
);

  always_ff @(posedge clk) begin
    if (rst || init) crc_q <= CRC_PRESET;
    else if (stb)    crc_q <= crc16_byte(crc_q, data);
  end

endmodule

// File: rtl/hdlc_rx_hold.sv
// Delay line that withholds the trailing check bytes (R7).
module hdlc_rx_hold #(
  parameter int FCS_BYTES = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       flush,
  input  logic       stb,
  input  logic [7:0] data,
  output logic       out_valid,
  output logic [7:0] out_data,
  output logic       out_first
);
  localparam int FW = $clog2(FCS_BYTES + 1);
  localparam logic [FW-1:0] FULL = FW'(FCS_BYTES);

  logic [7:0]    line_q [FCS_BYTES];
  logic [FW-1:0] fill_q;
  logic          started_q;

  always_ff @(posedge clk) begin
    if (stb && !flush) begin
      line_q[0] <= data;
      for (int i = 1; i < FCS_BYTES; i++) line_q[i] <= line_q[i-1];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      fill_q    <= '0;
      started_q <= 1'b0;
      out_valid <= 1'b0;
      out_first <= 1'b0;
      out_data  <= '0;
    end else begin
      out_valid <= 1'b0;
      out_first <= 1'b0;
      if (flush) begin
        fill_q    <= '0;
        started_q <= 1'b0;
      end else if (stb) begin
        if (fill_q == FULL) begin
          out_valid <= 1'b1;
          out_data  <= line_q[FCS_BYTES-1];
          out_first <= !started_q;
          started_q <= 1'b1;
        end else begin
          fill_q <= fill_q + 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/hdlc_rx_deframer.sv
module hdlc_rx_deframer
  import hdlc_rx_pkg::*;
#(
  parameter int MIN_LEN   = 62,
  parameter int MAX_LEN   = 1534,
  parameter int FCS_BYTES = 2,
  parameter int ABORT_RUN = 7,
  parameter int IDLE_RUN  = 15
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       rx_bit,
  output logic       out_valid,
  output logic [7:0] out_data,
  output logic       out_first,
  output logic       fr_done,
  output logic       fr_ok,
  output logic       line_idle
);
  localparam int CNT_W = $clog2(MAX_LEN + 2);
  localparam logic [CNT_W-1:0] MIN_V = CNT_W'(MIN_LEN);
  localparam logic [CNT_W-1:0] MAX_V = CNT_W'(MAX_LEN);

  rx_state_t        st_q;
  logic             bit_take, ev_flag, ev_abort, frame_end, boundary;
  logic             byte_stb, good;
  logic [7:0]       byte_val;
  logic [2:0]       phase;
  logic [CNT_W-1:0] nbytes;
  logic [15:0]      crc_q;

  assign boundary  = ev_flag || ev_abort;
  assign frame_end = (st_q == ST_FRAME) && boundary;

  hdlc_rx_flagdet #(.ABORT_RUN(ABORT_RUN), .IDLE_RUN(IDLE_RUN)) u_flag (
    .clk(clk), .rst(rst), .rx_bit(rx_bit), .in_frame(st_q == ST_FRAME),
    .bit_take(bit_take), .ev_flag(ev_flag), .ev_abort(ev_abort), .line_idle(line_idle)
  );

  hdlc_rx_packer #(.MAX_LEN(MAX_LEN)) u_pack (
    .clk(clk), .rst(rst), .clear(boundary), .bit_take(bit_take), .bit_val(rx_bit),
    .byte_stb(byte_stb), .byte_val(byte_val), .phase(phase), .nbytes(nbytes)
  );

  hdlc_rx_crc16 u_crc (
    .clk(clk), .rst(rst), .init(boundary), .stb(byte_stb), .data(byte_val), .crc_q(crc_q)
  );

  hdlc_rx_hold #(.FCS_BYTES(FCS_BYTES)) u_hold (
    .clk(clk), .rst(rst), .flush(boundary), .stb(byte_stb), .data(byte_val),
    .out_valid(out_valid), .out_data(out_data), .out_first(out_first)
  );

  // R1/R9/R11: hunt until a delimiter, drop back on abort.
  always_ff @(posedge clk) begin
    if (rst)           st_q <= ST_HUNT;
    else if (ev_abort) st_q <= ST_HUNT;
    else if (ev_flag)  st_q <= ST_FRAME;
  end

  // R5/R6/R8 verdict, made on the closing delimiter.
  assign good = ev_flag && (phase == 3'd7) && (nbytes >= MIN_V) &&
                (nbytes <= MAX_V) && (crc_q == CRC_RESIDUE);

  always_ff @(posedge clk) begin
    if (rst) begin
      fr_done <= 1'b0;
      fr_ok   <= 1'b0;
    end else begin
      fr_done <= frame_end && (nbytes != '0); // R4
      fr_ok   <= frame_end && (nbytes != '0) && good;
    end
  end

endmodule

// File: rtl/hdlc_rx_deframer_chk.sv
module hdlc_rx_deframer_chk #(
  parameter int MIN_LEN   = 62,
  parameter int MAX_LEN   = 1534,
  parameter int FCS_BYTES = 2
) (
  input logic clk,
  input logic rst,
  input logic rx_bit,
  input logic out_valid,
  input logic out_first,
  input logic fr_done,
  input logic fr_ok,
  input logic line_idle
);
  localparam int CW = $clog2(MAX_LEN + 1);
  localparam logic [CW-1:0] LO  = CW'(MIN_LEN - FCS_BYTES);
  localparam logic [CW-1:0] HI  = CW'(MAX_LEN - FCS_BYTES);
  localparam logic [CW-1:0] SAT = CW'(MAX_LEN);

  logic [CW-1:0] seen_q;

  always_ff @(posedge clk) begin
    if (rst || fr_done)               seen_q <= '0;
    else if (out_valid && seen_q != SAT) seen_q <= seen_q + 1'b1;
  end

  p_done_apart_r4: assert property (@(posedge clk) disable iff (rst) out_valid |-> !fr_done);
  p_ok_with_done_r4: assert property (@(posedge clk) disable iff (rst) fr_ok |-> fr_done);
  p_first_valid_r7: assert property (@(posedge clk) disable iff (rst) out_first |-> out_valid);
  p_first_at_start_r7: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_first) |-> (seen_q == '0));
  p_cont_mid_r7: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_first) |-> (seen_q != '0));
  p_ok_len_r6: assert property (@(posedge clk) disable iff (rst)
    fr_ok |-> (seen_q >= LO && seen_q <= HI));
  p_idle_ones_r10: assert property (@(posedge clk) disable iff (rst) line_idle |-> $past(rx_bit));

endmodule

bind hdlc_rx_deframer hdlc_rx_deframer_chk #(
  .MIN_LEN(MIN_LEN), .MAX_LEN(MAX_LEN), .FCS_BYTES(FCS_BYTES)
) u_chk (
  .clk(clk), .rst(rst), .rx_bit(rx_bit), .out_valid(out_valid), .out_first(out_first),
  .fr_done(fr_done), .fr_ok(fr_ok), .line_idle(line_idle)
);

// File: tb/hdlc_rx_deframer_bench.sv
`timescale 1ns/1ps
module hdlc_rx_deframer_bench;
  localparam int MIN_LEN = 62;
  localparam int MAX_LEN = 1534;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic rx_bit = 1'b1;
  logic out_valid, out_first, fr_done, fr_ok, line_idle;
  logic [7:0] out_data;

  int compared = 0;
  int mismatched = 0;
  int m_run = 0;
  int ones_tx = 0;
  bit finished = 0;
  string cur_req = "R11";
  logic [8:0] exp_q[$];
  bit stat_q[$];

  always #5 clk = ~clk;

  hdlc_rx_deframer u_hdlc_rx_deframer (
    .clk(clk), .rst(rst), .rx_bit(rx_bit), .out_valid(out_valid), .out_data(out_data),
    .out_first(out_first), .fr_done(fr_done), .fr_ok(fr_ok), .line_idle(line_idle)
  );

  task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [15:0] ref_crc(input logic [7:0] q[$]);
    logic [15:0] c = 16'hFFFF;
    foreach (q[k]) for (int b = 0; b < 8; b++)
      c = (c[0] ^ q[k][b]) ? ((c >> 1) ^ 16'h8408) : (c >> 1);
    return c;
  endfunction

  function automatic logic [7:0] pat(input int i, input int seed);
    if (i % 5 == 0) return 8'hFF;
    if (i % 7 == 3) return 8'h7E;
    return 8'(seed * 11 + i * 29);
  endfunction

  // Behavioural line model: run of ones for R10.
  always @(posedge clk) begin
    if (rst) m_run = 0;
    else if (rx_bit) begin if (m_run < 15) m_run++; end
    else m_run = 0;
  end

  always @(negedge clk) begin
    logic [8:0] e;
    if (rst) begin
      check(!out_valid && !fr_done && !fr_ok && !line_idle && !out_first, "R11", "outputs in reset",
            {out_valid, fr_done, fr_ok, line_idle}, 0);
    end else begin
      check(line_idle == (m_run >= 15), "R10", "line_idle", line_idle, m_run >= 15);
      if (out_valid) begin
        if (exp_q.size() == 0) check(0, "R7", {cur_req, " unexpected byte"}, out_data, 0);
        else begin
          e = exp_q.pop_front();
          check(out_data == e[7:0], "R3", {cur_req, " data"}, out_data, e[7:0]);
          check(out_first == e[8], "R7", {cur_req, " first mark"}, out_first, e[8]);
        end
      end
      if (fr_done) begin
        if (stat_q.size() == 0) check(0, "R4", {cur_req, " unexpected status"}, fr_ok, 0);
        else check(fr_ok == stat_q.pop_front(), "R4", {cur_req, " status"}, fr_ok, !fr_ok);
      end
    end
  end

  task automatic tx_bit(input logic b);
    @(negedge clk);
    rx_bit = b;
  endtask

  task automatic tx_data_bit(input logic b);
    tx_bit(b);
    if (b) begin
      ones_tx++;
      if (ones_tx == 5) begin tx_bit(1'b0); ones_tx = 0; end // R2 stuffing
    end else ones_tx = 0;
  endtask

  task automatic tx_flag();
    tx_bit(1'b0);
    repeat (6) tx_bit(1'b1);
    tx_bit(1'b0);
    ones_tx = 0;
  endtask

  task automatic send_frame(input int plen, input int seed, input bit corrupt,
                            input int extra, input bit abort_it, input string req);
    logic [7:0] wb[$];
    logic [15:0] c;
    int nw;
    bit good;
    cur_req = req;
    for (int i = 0; i < plen; i++) wb.push_back(pat(i, seed));
    if (!abort_it) begin
      c = ~ref_crc(wb);
      wb.push_back(c[7:0]);
      wb.push_back(c[15:8]);
      if (corrupt) wb[3] = wb[3] ^ 8'h10;
    end
    nw = wb.size() + ((extra > 0) ? 1 : 0);
    for (int i = 0; i < nw - 2; i++) exp_q.push_back({(i == 0), wb[i]});
    good = !abort_it && !corrupt && (extra == 0) && wb.size() >= MIN_LEN && wb.size() <= MAX_LEN;
    if (nw > 0) stat_q.push_back(good);
    ones_tx = 0;
    foreach (wb[k]) for (int b = 0; b < 8; b++) tx_data_bit(wb[k][b]);
    for (int x = 0; x < extra; x++) tx_data_bit(1'b0);
    if (abort_it) begin
      tx_bit(1'b0);
      repeat (24) tx_bit(1'b1);
    end else tx_flag();
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    // R11: bits before the first delimiter are ignored.
    cur_req = "R11";
    for (int i = 0; i < 20; i++) tx_bit(logic'((i * 5 + 1) % 3 == 0));
    // R10: idle detection on a long run of ones.
    cur_req = "R10";
    repeat (20) tx_bit(1'b1);
    tx_flag();
    send_frame(60, 1, 0, 0, 0, "R6 R5 R2 minimum length");
    send_frame(62, 2, 0, 0, 0, "R12 shared delimiter");
    // R1: delimiters back to back, then two sharing one zero.
    cur_req = "R1";
    tx_flag();
    tx_flag();
    repeat (6) tx_bit(1'b1);
    tx_bit(1'b0);
    send_frame(59, 3, 0, 0, 0, "R6 short frame");
    send_frame(68, 4, 1, 0, 0, "R5 bad check");
    send_frame(64, 5, 0, 4, 0, "R8 odd bit count");
    send_frame(20, 6, 0, 0, 1, "R9 abort");
    cur_req = "R9";
    for (int i = 0; i < 16; i++) tx_bit(logic'(i % 3 == 0)); // ignored until delimiter
    tx_flag();
    send_frame(MAX_LEN - 2, 7, 0, 0, 0, "R6 maximum length");
    send_frame(MAX_LEN - 1, 8, 0, 0, 0, "R6 oversize");
    send_frame(98, 9, 0, 0, 0, "R3 R7 normal");
    cur_req = "R10";
    repeat (40) tx_bit(1'b1);
    tx_flag();
    repeat (10) @(negedge clk);
    check(exp_q.size() == 0, "R7", "bytes outstanding", exp_q.size(), 0);
    check(stat_q.size() == 0, "R4", "statuses outstanding", stat_q.size(), 0);
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      compared++;
      mismatched++;
      $display("FAIL R4 watchdog: actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

endmodule